// File: doc/BRIEF.md
# External Data-Memory Access Sequencer

This block sits beside a single-cycle 8051-class core and carries out its external data RAM reads and writes. It owns a small wait-state register that the core reads and writes over a simple special-function-register bus. When the core raises an access request, the block runs a bus sequence of four cycles plus the programmed wait count. The sequence has an address phase with the address-latch strobe, an active-low read or write strobe phase that the wait states stretch, and a hold phase. The core is stalled until the final cycle of that sequence.

Outside data accesses, the block shapes the address-latch strobe for ordinary instructions. The core presents each instruction's length in machine cycles. The strobe is high during the first half of that instruction's first cycle and low for the rest of the instruction. A run of one-cycle instructions therefore makes the strobe toggle at the core clock rate. Program fetches never use this bus.

Top module: `xmem_sequencer`

## Requirements
- R1: After reset the wait register holds 0, both bus strobes rdN and wrN are high (inactive), stall is low and the register reads back 8'h00.
- R2: A write on the register bus at address 8'h9F stores data bits [2:0]. A read at 8'h9F returns the stored value in bits [2:0] and zero in bits [7:3]. Any other address reads 8'h00, and writes to it leave the wait register unchanged.
- R3: An access with wait count n lasts 4+n cycles. Cycle 0 is the cycle in which accReq is seen while idle. stall is high in cycles 0 to 2+n and low in cycle 3+n.
- R4: For a read (accWrite=0), rdN is low exactly in cycles 1 to 2+n and wrN stays high. For a write, wrN is low in those cycles, rdN stays high, and busDataOe is high in the same cycles only.
- R5: busAddr equals the requested address in every cycle from 0 to 3+n. During a write's strobe cycles, busWrData equals the requested write data.
- R6: For a read, busRdData is captured on the clock edge that ends the last strobe cycle (2+n). It is presented on accRdData from cycle 3+n onward.
- R7: The wait count is taken from the register in cycle 0. A register write during an access changes only later accesses.
- R8: During an access, aleOut is high in the first (clock-high) half of cycle 0 and low at all other times of the access.
- R9: An instruction of length L (instrLen, 1 to 7, with 0 treated as 1) accepted with instrValid gives aleOut high in the first half of its first cycle only. It is low in the second half and in all later cycles of that instruction. A stream of one-cycle instructions gives aleOut high in the first half of every cycle.
- R10: instrValid is ignored while cycles of the current instruction remain. It is also ignored in a cycle in which an access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one machine cycle per period |
| rstN | input | 1 | Active-low asynchronous reset |
| sfrAddr | input | 8 | Register bus address |
| sfrWrEn | input | 1 | Register bus write enable |
| sfrWrData | input | 8 | Register bus write data |
| sfrRdData | output | 8 | Register bus read data (combinational) |
| accReq | input | 1 | Core requests an external data access (sampled while idle) |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | 16 | Access address |
| accWrData | input | 8 | Data to write |
| accRdData | output | 8 | Captured read data |
| stall | output | 1 | Holds the core during an access |
| instrValid | input | 1 | First cycle of an ordinary instruction |
| instrLen | input | 3 | Length of that instruction in cycles |
| busAddr | output | 16 | External address |
| busWrData | output | 8 | External write data |
| busDataOe | output | 1 | Write data drive enable |
| busRdData | input | 8 | External read data |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| aleOut | output | 1 | Address-latch strobe, high in first half of a cycle |

## Verification
Reads and writes are each run with every wait count from 0 to 7. The stall length, the strobe window and the bus-address hold then have to track n cycle by cycle, which separates a stretch that is off by one from a correct one. Read data on the bus is the true value only in the last strobe cycle and its complement in all other cycles, so a capture taken one cycle early or late shows up as wrong data. A register write in the middle of an access shows whether the count was taken at the start. Instructions of lengths 1 to 4 are run with instrValid held high throughout, so an extra acceptance would produce a visible extra strobe pulse. The strobe is sampled in both halves of every cycle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_STROBE = 2'd1,
    SEQ_HOLD   = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // cycle 0 of an access
    logic busy;     // cycles 1 .. 3+n
    logic capture;  // last strobe cycle of a read
  } seqCtl_t;

endpackage

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int WAIT_W = 3,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accReq,
  input  logic              accWrite,
  input  logic              instrValid,
  input  logic [LEN_W-1:0]  instrLen,
  input  logic [WAIT_W-1:0] waitVal,
  output seqCtl_t           ctl,
  output logic              stall,
  output logic              rdN,
  output logic              wrN,
  output logic              dataOe,
  output logic              aleOut
);

  localparam int CNT_W = WAIT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'((1 << WAIT_W));

  seqState_t        state;
  logic [CNT_W-1:0] strobeLeft;
  logic             wrLatch;
  logic [LEN_W-1:0] insLeft;
  logic             startNow;
  logic             instrTake;
  logic             aleCycle;
  logic             idleNoAcc;

  assign startNow  = (state == SEQ_IDLE) && accReq;
  assign idleNoAcc = (state == SEQ_IDLE) && !accReq;
  assign instrTake = idleNoAcc && instrValid && (insLeft == '0);
  assign aleCycle  = startNow || instrTake;

  // address-latch strobe: first half of the marked cycle only
  assign aleOut = aleCycle & clk;

  assign stall  = startNow || (state == SEQ_STROBE);
  assign rdN    = !((state == SEQ_STROBE) && !wrLatch);
  assign wrN    = !((state == SEQ_STROBE) && wrLatch);
  assign dataOe = (state == SEQ_STROBE) && wrLatch;

  assign ctl.start   = startNow;
  assign ctl.busy    = (state != SEQ_IDLE);
  assign ctl.capture = (state == SEQ_STROBE) && (strobeLeft == '0) && !wrLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      strobeLeft <= '0;
      wrLatch    <= 1'b0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (accReq) begin
            state      <= SEQ_STROBE;
            strobeLeft <= CNT_W'(waitVal) + CNT_W'(1);
            wrLatch    <= accWrite;
          end
        end
        SEQ_STROBE: begin
          if (strobeLeft == '0) begin
            state <= SEQ_HOLD;
          end else begin
            strobeLeft <= strobeLeft - CNT_W'(1);
          end
        end
        SEQ_HOLD: state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  // remaining cycles of the current ordinary instruction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insLeft <= '0;
    end else if (instrTake) begin
      insLeft <= (instrLen == '0) ? '0 : instrLen - LEN_W'(1);
    end else if (idleNoAcc && (insLeft != '0)) begin
      insLeft <= insLeft - LEN_W'(1);
    end
  end

  // R3: the strobe phase always ends in the hold phase
  a_r3_hold_after_strobe : assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_STROBE && strobeLeft == '0) |=> (state == SEQ_HOLD));

  // R3: the stretch counter never exceeds the widest wait setting
  a_r3_count_bound : assert property (@(posedge clk) disable iff (!rstN)
    strobeLeft <= CNT_MAX);

  // R4: the two bus strobes are never active together
  a_r4_strobes_exclusive : assert property (@(posedge clk) disable iff (!rstN)
    (rdN || wrN));

  // R3: stall drops in the hold cycle, handing control back to the core
  a_r3_stall_released : assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_HOLD) |-> !stall);

  // R10: an instruction in progress counts down without being reloaded
  a_r10_no_reload : assert property (@(posedge clk) disable iff (!rstN)
    (insLeft != '0 && idleNoAcc) |=> (insLeft == $past(insLeft) - LEN_W'(1)));

endmodule

// File: rtl/xmem_datapath.sv
module xmem_datapath
  import xmem_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          WAIT_W   = 3,
  parameter logic [7:0]  WAIT_SFR = 8'h9F
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [7:0]        sfrAddr,
  input  logic              sfrWrEn,
  input  logic [7:0]        sfrWrData,
  output logic [7:0]        sfrRdData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWrData,
  output logic [DATA_W-1:0] accRdData,
  input  logic [DATA_W-1:0] busRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic [WAIT_W-1:0] waitVal
);

  localparam int PAD_W = 8 - WAIT_W;

  logic [WAIT_W-1:0] waitReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wrReg;
  logic [DATA_W-1:0] rdReg;
  logic              sfrHit;

  assign sfrHit    = (sfrAddr == WAIT_SFR);
  assign sfrRdData = sfrHit ? {{PAD_W{1'b0}}, waitReg} : 8'h00;
  assign waitVal   = waitReg;
  assign busAddr   = ctl.start ? accAddr : addrReg;
  assign busWrData = wrReg;
  assign accRdData = rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitReg <= '0;
    end else if (sfrWrEn && sfrHit) begin
      waitReg <= sfrWrData[WAIT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
    end else if (ctl.start) begin
      addrReg <= accAddr;
      wrReg   <= accWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (ctl.capture) begin
      rdReg <= busRdData;
    end
  end

  // R5: the address is held for the rest of the access
  a_r5_addr_held : assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && !ctl.start) |-> (busAddr == $past(busAddr)));

  // R6: read data comes from the bus in the capture cycle
  a_r6_capture : assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (accRdData == $past(busRdData)));

  // R2: unused register bits always read back as zero
  a_r2_upper_zero : assert property (@(posedge clk) disable iff (!rstN)
    sfrRdData[7:WAIT_W] == '0);

endmodule

// File: rtl/xmem_sequencer.sv
module xmem_sequencer
  import xmem_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         DATA_W   = 8,
  parameter int         WAIT_W   = 3,
  parameter int         LEN_W    = 3,
  parameter logic [7:0] WAIT_SFR = 8'h9F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        sfrAddr,
  input  logic              sfrWrEn,
  input  logic [7:0]        sfrWrData,
  output logic [7:0]        sfrRdData,
  input  logic              accReq,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWrData,
  output logic [DATA_W-1:0] accRdData,
  output logic              stall,
  input  logic              instrValid,
  input  logic [LEN_W-1:0]  instrLen,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busRdData,
  output logic              rdN,
  output logic              wrN,
  output logic              aleOut
);

  seqCtl_t           ctl;
  logic [WAIT_W-1:0] waitVal;

  xmem_ctrl #(
    .WAIT_W (WAIT_W),
    .LEN_W  (LEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accReq     (accReq),
    .accWrite   (accWrite),
    .instrValid (instrValid),
    .instrLen   (instrLen),
    .waitVal    (waitVal),
    .ctl        (ctl),
    .stall      (stall),
    .rdN        (rdN),
    .wrN        (wrN),
    .dataOe     (busDataOe),
    .aleOut     (aleOut)
  );

  xmem_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WAIT_W   (WAIT_W),
    .WAIT_SFR (WAIT_SFR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sfrAddr   (sfrAddr),
    .sfrWrEn   (sfrWrEn),
    .sfrWrData (sfrWrData),
    .sfrRdData (sfrRdData),
    .accAddr   (accAddr),
    .accWrData (accWrData),
    .accRdData (accRdData),
    .busRdData (busRdData),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .waitVal   (waitVal)
  );

endmodule

// File: tb/xmem_sequencer_tb.sv
module xmem_sequencer_tb;

  typedef struct {
    string      tag;
    logic       stall;
    logic       rdN;
    logic       wrN;
    logic       oe;
    logic       ale;
    logic       chkAddr;
    logic [15:0] addr;
    logic       chkWr;
    logic [7:0] wrData;
    logic       chkRd;
    logic [7:0] rdData;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  sfrAddr = 8'h00;
  logic        sfrWrEn = 1'b0;
  logic [7:0]  sfrWrData = 8'h00;
  logic [7:0]  sfrRdData;
  logic        accReq = 1'b0;
  logic        accWrite = 1'b0;
  logic [15:0] accAddr = 16'h0000;
  logic [7:0]  accWrData = 8'h00;
  logic [7:0]  accRdData;
  logic        stall;
  logic        instrValid = 1'b0;
  logic [2:0]  instrLen = 3'd0;
  logic [15:0] busAddr;
  logic [7:0]  busWrData;
  logic        busDataOe;
  logic [7:0]  busRdData = 8'h00;
  logic        rdN;
  logic        wrN;
  logic        aleOut;

  int checks = 0;
  int fails  = 0;
  expItem_t expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  xmem_sequencer u_dut (
    .clk(clk), .rstN(rstN),
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData), .sfrRdData(sfrRdData),
    .accReq(accReq), .accWrite(accWrite), .accAddr(accAddr), .accWrData(accWrData),
    .accRdData(accRdData), .stall(stall), .instrValid(instrValid), .instrLen(instrLen),
    .busAddr(busAddr), .busWrData(busWrData), .busDataOe(busDataOe), .busRdData(busRdData),
    .rdN(rdN), .wrN(wrN), .aleOut(aleOut)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: one expected item per cycle, both clock halves sampled
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() != 0) begin
        expItem_t e;
        logic sStall, sRd, sWr, sOe, sAleHi, sAleLo;
        logic [15:0] sAddr;
        logic [7:0] sWd, sRdd;
        bit bad;
        e = expQ.pop_front();
        sStall = stall; sRd = rdN; sWr = wrN; sOe = busDataOe; sAleHi = aleOut;
        sAddr = busAddr; sWd = busWrData; sRdd = accRdData;
        #10;
        sAleLo = aleOut;
        bad = (sStall !== e.stall) || (sRd !== e.rdN) || (sWr !== e.wrN) ||
              (sOe !== e.oe) || (sAleHi !== e.ale) || (sAleLo !== 1'b0) ||
              (e.chkAddr && sAddr !== e.addr) || (e.chkWr && sWd !== e.wrData) ||
              (e.chkRd && sRdd !== e.rdData);
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s got stall=%b rdN=%b wrN=%b oe=%b ale=%b/%b addr=%h wd=%h rd=%h expected stall=%b rdN=%b wrN=%b oe=%b ale=%b/0 addr=%h wd=%h rd=%h",
                   e.tag, sStall, sRd, sWr, sOe, sAleHi, sAleLo, sAddr, sWd, sRdd,
                   e.stall, e.rdN, e.wrN, e.oe, e.ale, e.addr, e.wrData, e.rdData);
        end
      end
    end
  end

  // driver: one access, n = wait count in effect, optional register write in cycle 1
  task automatic doAccess(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                          input logic [7:0] rd, input int n, input bit poke,
                          input logic [7:0] pokeVal, input string tag);
    for (int k = 0; k <= 3 + n; k++) begin
      expItem_t e;
      bit strobe;
      @(posedge clk);
      #1;
      strobe    = (k >= 1) && (k <= 2 + n);
      accReq    = (k == 0);
      accWrite  = wr;
      accAddr   = a;
      accWrData = wd;
      busRdData = (k == 2 + n) ? rd : ~rd;
      sfrWrEn   = poke && (k == 1);
      sfrAddr   = 8'h9F;
      sfrWrData = pokeVal;
      e.tag     = $sformatf("%s n=%0d wr=%0b cycle %0d", tag, n, wr, k);
      e.stall   = (k < 3 + n);
      e.rdN     = !(strobe && !wr);
      e.wrN     = !(strobe && wr);
      e.oe      = strobe && wr;
      e.ale     = (k == 0);
      e.chkAddr = 1'b1;
      e.addr    = a;
      e.chkWr   = wr && strobe;
      e.wrData  = wd;
      e.chkRd   = !wr && (k == 3 + n);
      e.rdData  = rd;
      expQ.push_back(e);
    end
    @(posedge clk);
    #1;
    accReq  = 1'b0;
    sfrWrEn = 1'b0;
    wait (expQ.size() == 0);
  endtask

  // driver: one ordinary instruction, instrValid held high throughout (R10)
  task automatic doInstr(input int len, input string tag);
    int eff;
    eff = (len == 0) ? 1 : len;
    for (int k = 0; k < eff; k++) begin
      expItem_t e;
      @(posedge clk);
      #1;
      instrValid = 1'b1;
      instrLen   = 3'(len);
      e = '{tag: $sformatf("%s len=%0d cycle %0d", tag, len, k),
            stall: 1'b0, rdN: 1'b1, wrN: 1'b1, oe: 1'b0, ale: (k == 0),
            chkAddr: 1'b0, addr: 16'h0, chkWr: 1'b0, wrData: 8'h0,
            chkRd: 1'b0, rdData: 8'h0};
      expQ.push_back(e);
    end
    wait (expQ.size() == 0);
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk);
    #1;
    sfrAddr = a; sfrWrEn = 1'b1; sfrWrData = d;
    @(posedge clk);
    #1;
    sfrWrEn = 1'b0;
  endtask

  task automatic sfrReadCheck(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk);
    #1;
    sfrAddr = a; sfrWrEn = 1'b0;
    #4;
    check(tag, {8'h00, sfrRdData}, {8'h00, exp});
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired got hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 stall", {15'h0, stall}, 16'h0);
    check("R1 rdN", {15'h0, rdN}, 16'h1);
    check("R1 wrN", {15'h0, wrN}, 16'h1);
    sfrAddr = 8'h9F;
    #1;
    check("R1 wait reg", {8'h0, sfrRdData}, 16'h0);
    rstN = 1'b1;

    // R2: register bus
    sfrWrite(8'h9F, 8'hFD);
    sfrReadCheck(8'h9F, 8'h05, "R2 upper bits zero");
    sfrWrite(8'h9E, 8'h07);
    sfrReadCheck(8'h9F, 8'h05, "R2 other address no write");
    sfrReadCheck(8'h9E, 8'h00, "R2 other address reads zero");

    // R3 R4 R5 R6 R8: every wait count, read then write
    for (int n = 0; n < 8; n++) begin
      sfrWrite(8'h9F, 8'(n));
      doAccess(1'b0, 16'hA500 + 16'(n), 8'h00, 8'h3C + 8'(n), n, 1'b0, 8'h0, "R3 R4 R6 R8 read");
      doAccess(1'b1, 16'h5A10 + 16'(n), 8'hC0 + 8'(n), 8'h00, n, 1'b0, 8'h0, "R3 R4 R5 write");
    end

    // R7: register write mid-access affects only the next access
    sfrWrite(8'h9F, 8'd2);
    doAccess(1'b0, 16'h1234, 8'h00, 8'h99, 2, 1'b1, 8'h07, "R7 sampled at start");
    sfrReadCheck(8'h9F, 8'h07, "R7 new value stored");
    doAccess(1'b0, 16'h4321, 8'h00, 8'h66, 7, 1'b0, 8'h0, "R7 next access");

    // R9 R10: instruction strobe pattern
    for (int len = 1; len <= 4; len++) doInstr(len, "R9 R10 instr");
    doInstr(1, "R9 single");
    doInstr(1, "R9 single");
    doInstr(0, "R9 zero length");
    @(posedge clk);
    #1;
    instrValid = 1'b0;

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule